// File: doc/BRIEF.md
# Receive Descriptor Ring Status Write-Back Engine

This block looks after a ring of receive descriptors kept in a small local memory. Each descriptor is four 16-bit words. Only word 0 carries control and status: an ownership flag, an end-of-ring mark, a chaining flag, the copied frame-header bits, an error flag and the upper eight bits of a buffer address. The host fills the ring through a word-wide host port and gives each descriptor to the engine by setting its ownership flag. A frame-side source presents one event per filled buffer. The event either says that a buffer is full and the frame goes on, or it marks the end of the frame and carries an error flag and the header bits C/R, FECN, BECN and DE.

The engine follows the ring as buffers fill, chaining one frame across as many descriptors as it needs. When a frame ends and is to be reported, the engine walks the chain from its first descriptor to its last and writes one descriptor's word 0 per cycle. That single write both publishes the status and clears ownership. While it walks, it holds `ev_ready` low. A bad frame with error reporting off is silently discarded: the engine keeps its descriptors and rewinds to the start of the chain. If a buffer is needed and the next descriptor is still the host's, a sticky no-buffer flag is raised and the rest of that frame is thrown away.

Top module: `rxd_ring_wb`

## Requirements
- R1: After reset every memory word reads 0, `cur_desc` is 0, `ev_ready` is 1 and `nobuf` is 0.
- R2: A host write lands in the addressed word at the next clock edge, and `host_rdata` shows word `host_addr` combinationally. Word address = descriptor index × 4 + word number. If the host and the engine write the same word in one cycle, the host value is kept.
- R3: Word 0 layout: bit 15 ownership (1 = engine), 14 end of ring, 13 C/R, 12 end of long frame, 11 FECN, 10 BECN, 9 DE, 8 frame in error, 7:0 address high byte. For a good frame held in one descriptor, the engine writes word 0 one cycle after accepting the end event. It sets ownership to 0, end of long frame to 1, the four header bits to the event's values and frame in error to 0.
- R4: For a frame chained over several descriptors, the engine writes word 0 of each descriptor in ring order, one per cycle, starting the cycle after the end event is accepted. Every descriptor but the last gets end of long frame 0, and the last gets 1. `ev_ready` is 0 for exactly as many cycles as there are descriptors in the chain.
- R5: A frame ending with `ev_err` = 1 while `err_rpt_en` = 1 is released like a good frame, with frame in error = 1.
- R6: A frame ending with `ev_err` = 1 while `err_rpt_en` = 0 changes no memory word, and `cur_desc` returns to the frame's first descriptor.
- R7: An event accepted while the current descriptor has ownership 0 sets `nobuf`, which stays 1 until reset. The events that follow, up to and including the frame's end event, change neither memory nor `cur_desc`, and `cur_desc` returns to the frame's first descriptor.
- R8: After a descriptor is used, the next index is 0 if its end-of-ring bit is 1 or it is descriptor NDESC-1; otherwise it is the index plus one.
- R9: The engine never changes words 1 to 3, the end-of-ring bit or the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address (descriptor × 4 + word) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at host_addr, combinational |
| err_rpt_en | input | 1 | Release errored frames with the error flag set |
| ev_valid | input | 1 | Buffer event present |
| ev_ready | output | 1 | Engine accepts an event this cycle |
| ev_last | input | 1 | Event ends the frame (else buffer full, frame continues) |
| ev_err | input | 1 | Frame aborted or failed its check (end event only) |
| ev_cr | input | 1 | Header C/R bit |
| ev_fecn | input | 1 | Header forward congestion bit |
| ev_becn | input | 1 | Header backward congestion bit |
| ev_de | input | 1 | Header discard-eligible bit |
| nobuf | output | 1 | Sticky: a buffer was needed but the descriptor was host-owned |
| cur_desc | output | IDX_W | Index of the next descriptor the engine will use |

## Verification
An event is accepted at the edge where `ev_valid` and `ev_ready` are both high. Pointer moves and `nobuf` show up right after that edge. A released chain of k descriptors gets its word-0 writes at the k edges that follow, and `ev_ready` is low over the same span. Host writes appear one edge later, while host reads are immediate. The bench model applies exactly these delays and compares `ev_ready`, `nobuf`, `cur_desc` and the word under `host_addr` at every falling edge. Directed checks wait for `ev_ready` to return before they read descriptors back. The host-priority case places a host write on the exact edge where the walk writes the same word.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    // word-0 bit positions; the host decodes these, so they are fixed
    localparam int W0_OWN  = 15;
    localparam int W0_EOR  = 14;
    localparam int W0_CR   = 13;
    localparam int W0_ELF  = 12;
    localparam int W0_FECN = 11;
    localparam int W0_BECN = 10;
    localparam int W0_DE   = 9;
    localparam int W0_FER  = 8;

    typedef struct packed {
        logic cr;
        logic fecn;
        logic becn;
        logic de;
        logic fer;
    } rx_stat_t;

    typedef enum logic {ST_IDLE, ST_WALK} eng_mode_e;
endpackage

// File: rtl/rxd_word0_fmt.sv
module rxd_word0_fmt
    import rxd_pkg::*;
(
    input  logic [15:0] old_w0,
    input  rx_stat_t    stat,
    input  logic        elf,
    output logic [15:0] new_w0
);
    always_comb begin
        new_w0          = old_w0;
        new_w0[W0_OWN]  = 1'b0;
        new_w0[W0_CR]   = stat.cr;
        new_w0[W0_ELF]  = elf;
        new_w0[W0_FECN] = stat.fecn;
        new_w0[W0_BECN] = stat.becn;
        new_w0[W0_DE]   = stat.de;
        new_w0[W0_FER]  = stat.fer;
    end
endmodule

// File: rtl/rxd_desc_mem.sv
module rxd_desc_mem
    import rxd_pkg::*;
#(
    parameter int NDESC  = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [15:0]       eng_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [15:0]       rd_word0
);
    localparam int NWORD = NDESC * 4;

    logic [15:0] mem_d [NWORD];
    logic [15:0] mem_q [NWORD];
    logic [ADDR_W-1:0] eng_addr;
    logic              collide;

    assign eng_addr   = {eng_idx, 2'b00};
    assign collide    = host_we && (host_addr == eng_addr);
    assign host_rdata = mem_q[host_addr];
    assign rd_word0   = mem_q[{rd_idx, 2'b00}];

    always_comb begin
        for (int i = 0; i < NWORD; i++) mem_d[i] = mem_q[i];
        if (eng_we) mem_d[eng_addr] = eng_wdata;
        if (host_we && (int'(host_addr) < NWORD)) mem_d[host_addr] = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NWORD; i++) mem_q[i] <= mem_d[i];
        end
    end

    assert_host_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && collide) |=> (mem_q[$past(host_addr)] == $past(host_wdata)));

    assert_own_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !collide) |=> !mem_q[$past(eng_addr)][W0_OWN]);

    assert_keep_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !collide) |=>
        ({mem_q[$past(eng_addr)][W0_EOR], mem_q[$past(eng_addr)][7:0]} ==
         $past({mem_q[eng_addr][W0_EOR], mem_q[eng_addr][7:0]})));
endmodule

// File: rtl/rxd_ring_ctrl.sv
module rxd_ring_ctrl
    import rxd_pkg::*;
#(
    parameter int NDESC = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_rpt_en,
    input  logic             ev_valid,
    input  logic             ev_last,
    input  logic             ev_err,
    input  logic             ev_cr,
    input  logic             ev_fecn,
    input  logic             ev_becn,
    input  logic             ev_de,
    output logic             ev_ready,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [15:0]      rd_word0,
    output logic             eng_we,
    output logic [IDX_W-1:0] eng_idx,
    output rx_stat_t         eng_stat,
    output logic             eng_elf,
    output logic             nobuf,
    output logic [IDX_W-1:0] cur_desc
);
    typedef struct packed {
        eng_mode_e        mode;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] head;
        logic             in_frame;
        logic             drop;
        logic             nobuf;
        logic [IDX_W-1:0] walk;
        logic [IDX_W-1:0] last_idx;
        rx_stat_t         stat;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [IDX_W-1:0] chain_head;
    logic             cur_eor;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i, input logic eor);
        if (eor || (int'(i) == NDESC - 1)) return '0;
        return i + IDX_W'(1);
    endfunction

    assign rd_idx     = (st_q.mode == ST_WALK) ? st_q.walk : st_q.ptr;
    assign cur_eor    = rd_word0[W0_EOR];
    assign chain_head = st_q.in_frame ? st_q.head : st_q.ptr;
    assign ev_ready   = (st_q.mode == ST_IDLE);
    assign eng_idx    = st_q.walk;
    assign eng_stat   = st_q.stat;
    assign nobuf      = st_q.nobuf;
    assign cur_desc   = st_q.ptr;

    always_comb begin
        st_d    = st_q;
        eng_we  = 1'b0;
        eng_elf = 1'b0;
        if (st_q.mode == ST_WALK) begin
            eng_we  = 1'b1;
            eng_elf = (st_q.walk == st_q.last_idx);
            if (st_q.walk == st_q.last_idx) begin
                st_d.mode = ST_IDLE;
                st_d.ptr  = step_idx(st_q.walk, cur_eor);
            end else begin
                st_d.walk = step_idx(st_q.walk, cur_eor);
            end
        end else if (ev_valid) begin
            if (st_q.drop) begin
                if (ev_last) st_d.drop = 1'b0;
            end else if (!rd_word0[W0_OWN]) begin
                st_d.nobuf    = 1'b1;
                st_d.drop     = !ev_last;
                st_d.ptr      = chain_head;
                st_d.in_frame = 1'b0;
            end else if (!ev_last) begin
                st_d.head     = chain_head;
                st_d.in_frame = 1'b1;
                st_d.ptr      = step_idx(st_q.ptr, cur_eor);
            end else if (ev_err && !err_rpt_en) begin
                st_d.ptr      = chain_head;
                st_d.in_frame = 1'b0;
            end else begin
                st_d.mode     = ST_WALK;
                st_d.walk     = chain_head;
                st_d.last_idx = st_q.ptr;
                st_d.in_frame = 1'b0;
                st_d.stat     = '{cr: ev_cr, fecn: ev_fecn, becn: ev_becn,
                                  de: ev_de, fer: ev_err};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_nobuf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf |=> nobuf);

    assert_ptr_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_desc) < NDESC);

    assert_walk_blocks_events_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && (eng_idx != st_q.last_idx)) |=> !ev_ready);
endmodule

// File: rtl/rxd_ring_wb.sv
module rxd_ring_wb
    import rxd_pkg::*;
#(
    parameter  int NDESC  = 8,
    localparam int IDX_W  = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              err_rpt_en,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic              ev_last,
    input  logic              ev_err,
    input  logic              ev_cr,
    input  logic              ev_fecn,
    input  logic              ev_becn,
    input  logic              ev_de,
    output logic              nobuf,
    output logic [IDX_W-1:0]  cur_desc
);
    logic [IDX_W-1:0] rd_idx;
    logic [15:0]      rd_word0;
    logic             eng_we;
    logic [IDX_W-1:0] eng_idx;
    rx_stat_t         eng_stat;
    logic             eng_elf;
    logic [15:0]      eng_wdata;

    rxd_ring_ctrl #(.NDESC(NDESC), .IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .err_rpt_en(err_rpt_en),
        .ev_valid(ev_valid), .ev_last(ev_last), .ev_err(ev_err),
        .ev_cr(ev_cr), .ev_fecn(ev_fecn), .ev_becn(ev_becn), .ev_de(ev_de),
        .ev_ready(ev_ready), .rd_idx(rd_idx), .rd_word0(rd_word0),
        .eng_we(eng_we), .eng_idx(eng_idx), .eng_stat(eng_stat),
        .eng_elf(eng_elf), .nobuf(nobuf), .cur_desc(cur_desc)
    );

    rxd_word0_fmt fmt_i (
        .old_w0(rd_word0), .stat(eng_stat), .elf(eng_elf), .new_w0(eng_wdata)
    );

    rxd_desc_mem #(.NDESC(NDESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) mem_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_we(eng_we),
        .eng_idx(eng_idx), .eng_wdata(eng_wdata), .rd_idx(rd_idx),
        .rd_word0(rd_word0)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cur_desc == '0 && ev_ready && !nobuf));
endmodule

// File: tb/rxd_ring_wb_tb_top.sv
`timescale 1ns/1ps
module rxd_ring_wb_tb_top;
    localparam int ND = 8;
    localparam int NW = ND * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic err_rpt_en = 1'b0;
    logic ev_valid = 1'b0, ev_last = 1'b0, ev_err = 1'b0;
    logic ev_cr = 1'b0, ev_fecn = 1'b0, ev_becn = 1'b0, ev_de = 1'b0;
    logic ev_ready, nobuf;
    logic [2:0] cur_desc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxd_ring_wb #(.NDESC(ND)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .err_rpt_en(err_rpt_en),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_last(ev_last), .ev_err(ev_err),
        .ev_cr(ev_cr), .ev_fecn(ev_fecn), .ev_becn(ev_becn), .ev_de(ev_de),
        .nobuf(nobuf), .cur_desc(cur_desc)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] mm [NW];
    int m_ptr, m_head, m_busy_unused;
    bit m_in, m_drop, m_nobuf;
    int wq[$];
    int w_last;
    logic [15:0] w_stat;

    function automatic int nxt(input int i);
        if (mm[i*4][14] || i == ND - 1) return 0;
        return i + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mm[i]) mm[i] = '0;
            m_ptr = 0; m_head = 0; m_in = 0; m_drop = 0; m_nobuf = 0;
            wq.delete();
        end else begin
            if (wq.size() != 0) begin
                int idx;
                idx = wq.pop_front();
                mm[idx*4] = (mm[idx*4] & 16'h40FF) | w_stat |
                            ((idx == w_last) ? 16'h1000 : 16'h0000);
                if (wq.size() == 0) m_ptr = nxt(idx);
            end else if (ev_valid) begin
                int hd;
                hd = m_in ? m_head : m_ptr;
                if (m_drop) begin
                    if (ev_last) m_drop = 0;
                end else if (!mm[m_ptr*4][15]) begin
                    m_nobuf = 1; m_drop = !ev_last; m_ptr = hd; m_in = 0;
                end else if (!ev_last) begin
                    m_head = hd; m_in = 1; m_ptr = nxt(m_ptr);
                end else if (ev_err && !err_rpt_en) begin
                    m_ptr = hd; m_in = 0;
                end else begin
                    int k;
                    k = hd;
                    forever begin
                        wq.push_back(k);
                        if (k == m_ptr) break;
                        k = nxt(k);
                    end
                    w_last = m_ptr;
                    m_in = 0;
                    w_stat = {2'b00, ev_cr, 1'b0, ev_fecn, ev_becn, ev_de, ev_err, 8'h00};
                end
            end
            if (host_we) mm[host_addr] = host_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 model ev_ready", {15'd0, ev_ready}, {15'd0, wq.size() == 0});
            check("R7 model nobuf", {15'd0, nobuf}, {15'd0, m_nobuf});
            check("R8 model cur_desc", {13'd0, cur_desc}, 16'(m_ptr));
            check("R2 model host_rdata", host_rdata, mm[host_addr]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hwrite(input int a, input logic [15:0] d);
        @(negedge clk); #1;
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic hread(input string tag, input int a, input logic [15:0] exp);
        @(negedge clk); #1;
        host_addr = 5'(a);
        @(negedge clk);
        check(tag, host_rdata, exp);
    endtask

    task automatic send(input bit last, input bit err, input logic [3:0] hdr);
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
        #1;
        ev_valid = 1'b1; ev_last = last; ev_err = err;
        {ev_cr, ev_fecn, ev_becn, ev_de} = hdr;
        @(negedge clk); #1;
        ev_valid = 1'b0; ev_last = 1'b0; ev_err = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ev_ready) @(negedge clk);
    endtask

    function automatic logic [15:0] side_word(input int d, input int w);
        return {4'(w), 4'(d), 8'h5A};
    endfunction

    initial begin
        int tmo;
        tmo = 0;
        while (!done && tmo < 20000) begin
            @(posedge clk);
            tmo++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ev_ready", {15'd0, ev_ready}, 16'd1);
        check("R1 nobuf", {15'd0, nobuf}, 16'd0);
        check("R1 cur_desc", {13'd0, cur_desc}, 16'd0);
        hread("R1 word 0", 0, 16'h0000);
        hread("R1 word 31", 31, 16'h0000);

        // fill ring: six owned descriptors, end of ring on 5
        for (int d = 0; d < ND; d++) begin
            for (int w = 1; w < 4; w++) hwrite(d*4 + w, side_word(d, w));
        end
        for (int d = 0; d < 6; d++)
            hwrite(d*4, 16'h80A0 | 16'(d) | ((d == 5) ? 16'h4000 : 16'h0));
        hread("R2 host write readback", 20, 16'hC0A5);

        // R3 single good frame: cr=1 fecn=0 becn=1 de=1
        send(1, 0, 4'b1011);
        wait_idle();
        hread("R3 single frame word0", 0, 16'h36A0);
        check("R3 pointer advance", {13'd0, cur_desc}, 16'd1);

        // R4 chained frame over 1,2,3 with fecn=1
        send(0, 0, 4'b0100);
        send(0, 0, 4'b0100);
        send(1, 0, 4'b0100);
        wait_idle();
        hread("R4 chain first elf=0", 4, 16'h08A1);
        hread("R4 chain middle elf=0", 8, 16'h08A2);
        hread("R4 chain last elf=1", 12, 16'h18A3);
        check("R4 pointer after chain", {13'd0, cur_desc}, 16'd4);

        // R6 bad frame, reporting off, spans 4 and 5
        err_rpt_en = 1'b0;
        send(0, 0, 4'b0000);
        send(1, 1, 4'b0000);
        wait_idle();
        hread("R6 desc4 untouched", 16, 16'h80A4);
        hread("R6 desc5 untouched", 20, 16'hC0A5);
        check("R6 rewind to head", {13'd0, cur_desc}, 16'd4);

        // R5 bad frame, reporting on
        err_rpt_en = 1'b1;
        send(1, 1, 4'b0000);
        wait_idle();
        hread("R5 error flag set", 16, 16'h11A4);
        err_rpt_en = 1'b0;

        // R8 end-of-ring wrap from 5 to 0
        send(1, 0, 4'b0000);
        wait_idle();
        hread("R8 eor desc word0", 20, 16'h50A5);
        check("R8 wrap at eor", {13'd0, cur_desc}, 16'd0);

        // R7 descriptor 0 belongs to host: frame dropped
        send(0, 0, 4'b1111);
        check("R7 nobuf raised", {15'd0, nobuf}, 16'd1);
        send(0, 0, 4'b1111);
        send(1, 0, 4'b1111);
        wait_idle();
        hread("R7 desc0 unchanged", 0, 16'h36A0);
        check("R7 pointer held", {13'd0, cur_desc}, 16'd0);
        check("R7 nobuf sticky", {15'd0, nobuf}, 16'd1);

        // R2 host write collides with engine write of desc1 word0
        hwrite(0, 16'h80A0);
        hwrite(4, 16'h80A1);
        send(0, 0, 4'b0000);
        send(1, 0, 4'b0000);
        @(negedge clk); #1;
        host_we = 1'b1; host_addr = 5'd4; host_wdata = 16'hBEEF;
        @(negedge clk); #1;
        host_we = 1'b0;
        wait_idle();
        hread("R2 engine write of desc0", 0, 16'h00A0);
        hread("R2 host wins collision", 4, 16'hBEEF);
        check("R2 pointer after pair", {13'd0, cur_desc}, 16'd2);

        // R8 wrap at last index with end of ring cleared everywhere
        for (int d = 2; d < ND; d++) hwrite(d*4, 16'h80A0 | 16'(d));
        for (int d = 2; d < ND; d++) send(1, 0, 4'b0000);
        wait_idle();
        hread("R8 last index word0", 28, 16'h10A7);
        check("R8 wrap at NDESC-1", {13'd0, cur_desc}, 16'd0);

        // R9 side words intact
        for (int d = 0; d < ND; d++)
            for (int w = 1; w < 4; w++)
                hread("R9 side word", d*4 + w, side_word(d, w));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule